// File: doc/BRIEF.md
# Trigger-Paced Stream Prefetch Table

This block keeps a small table of prefetch streams that software sets up before a loop. Each stream has three parts: a current data address, a signed stride, and the PC of one instruction in the loop body that retires once per iteration. The block watches the retired-instruction port. Each time a retired PC equals a live stream's trigger PC, the block sends one prefetch request for that stream's current address and then moves the address on by the stride. Prefetches therefore keep pace with the loop, and the loop body needs no prefetch instructions of its own.

Software allocates a stream by writing a slot index with its settings, and frees the slot when the loop ends. Three options are set at allocation. An iteration divider makes only every N-th trigger match produce a prefetch. A loop-body length starts a prolog, which is a burst of requests that runs the stream ahead of the loop by enough iterations to cover memory latency. A block-size code is passed unchanged on every request.

Requests leave on a valid/ready port. The lowest-numbered stream with work has priority. Pending trigger matches are counted per stream up to a small limit.

Top module: `stream_prefetch_table`

## Requirements
- R1: While reset is asserted and directly after it, no stream is live and `req_valid_o` is low.
- R2: A config write with `cfg_alloc_i`=1 loads slot `cfg_idx_i` with start address, stride, trigger PC, divider, body length and block code, and marks the slot live. Writing to a live slot replaces all of its settings and clears its pending work.
- R3: A retired PC equal to a live slot's trigger produces one request carrying that slot's current address. When the request is accepted, the address advances by the 32-bit two's-complement stride, wrapping modulo 2^32.
- R4: A config write with `cfg_alloc_i`=0 frees the slot and drops its pending work. A retired PC that matches only free slots produces no request.
- R5: When several slots match in the same cycle, each queues its own request. Requests are sent one per cycle in ascending slot order, and `req_id_o` carries the slot index.
- R6: While `req_ready_i` is low, a slot keeps at most 3 pending trigger requests and ignores further matches. Its address changes only when a request is accepted.
- R7: With divider N ≥ 2, a slot produces a request only on its N-th, 2N-th, … trigger match. A divider of 0 or 1 produces a request on every match.
- R8: With body length B ≠ 0, allocation queues ceil(MEM_LAT/B) prolog requests. These go out back-to-back while ready is high, each one advancing the address, and they are served before that slot's trigger requests. B = 0 queues none.
- R9: Every request carries the block-size code of the slot it was issued for on `req_blk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_valid_i | input | 1 | Config write strobe |
| cfg_alloc_i | input | 1 | 1 = allocate/overwrite slot, 0 = free slot |
| cfg_idx_i | input | 2 | Slot index |
| cfg_addr_i | input | 32 | Start data address |
| cfg_stride_i | input | 32 | Signed stride |
| cfg_trig_i | input | 32 | Trigger instruction PC |
| cfg_every_i | input | 8 | Iterations between prefetches |
| cfg_body_i | input | 8 | Loop-body instruction count (0 = no prolog) |
| cfg_blk_i | input | 4 | Prefetch block-size code |
| ret_valid_i | input | 1 | Retired-instruction strobe |
| ret_pc_i | input | 32 | Retired-instruction PC |
| req_valid_o | output | 1 | Prefetch request valid |
| req_ready_i | input | 1 | Prefetch request accepted |
| req_addr_o | output | 32 | Prefetch data address |
| req_blk_o | output | 4 | Block-size code of the request |
| req_id_o | output | 2 | Slot that issued the request |

## Verification
The hardest state to reach is a slot whose pending count is at its limit while a prolog burst, a divider phase and competing lower-numbered slots are all active. Free-running random traffic rarely holds all of these at once. The stimulus therefore uses directed phases: one holds ready low across five trigger matches, one lets three slots match a single PC together, and one allocates a prolog under stall. A seeded random phase then draws trigger PCs from a small set shared by the slots. It allocates and frees slots at random, mixes stalls into the ready line, and uses strides near the address wrap, with a reference model in the bench checking every cycle.

// File: rtl/spt_pkg.sv
package spt_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 8;
  localparam int BLK_W  = 4;
  localparam int PEND_W = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] stride;
    logic [ADDR_W-1:0] trig;
    logic [CNT_W-1:0]  every;
    logic [CNT_W-1:0]  body;
    logic [BLK_W-1:0]  blk;
  } spt_cfg_t;
endpackage

// File: rtl/spt_entry.sv
module spt_entry
  import spt_pkg::*;
#(
  parameter int MEM_LAT = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_alloc_i,
  input  spt_cfg_t          cfg_i,
  input  logic              ret_valid_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic              grant_i,
  output logic              valid_o,
  output logic              want_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BLK_W-1:0]  blk_o
);
  localparam int PW = $clog2(MEM_LAT + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic              valid_q;
  logic [ADDR_W-1:0] cur_q, stride_q, trig_q;
  logic [CNT_W-1:0]  every_q, mod_q, mod_d;
  logic [BLK_W-1:0]  blk_q;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [PW-1:0]     prolog_q, prolog_d, prolog_n;
  logic              match, hit, dec_pend;

  always_comb begin
    if (cfg_i.body == '0) prolog_n = '0;
    else prolog_n = PW'((32'(MEM_LAT) + 32'(cfg_i.body) - 32'd1) / 32'(cfg_i.body));
  end

  assign match = valid_q && ret_valid_i && (ret_pc_i == trig_q);

  // divider: request only when the counter wraps to zero
  always_comb begin
    hit   = 1'b0;
    mod_d = mod_q;
    if (match) begin
      if (every_q <= CNT_W'(1)) hit = 1'b1;
      else if (mod_q == every_q - CNT_W'(1)) begin
        hit   = 1'b1;
        mod_d = '0;
      end else mod_d = mod_q + CNT_W'(1);
    end
  end

  assign dec_pend = grant_i && (prolog_q == '0);

  always_comb begin
    prolog_d = prolog_q;
    if (grant_i && prolog_q != '0) prolog_d = prolog_q - PW'(1);
    pend_d = pend_q;
    if (hit && !dec_pend && pend_q != PEND_MAX) pend_d = pend_q + PEND_W'(1);
    else if (dec_pend && !hit) pend_d = pend_q - PEND_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      cur_q    <= '0;
      stride_q <= '0;
      trig_q   <= '0;
      every_q  <= '0;
      mod_q    <= '0;
      blk_q    <= '0;
      pend_q   <= '0;
      prolog_q <= '0;
    end else if (cfg_we_i) begin
      valid_q  <= cfg_alloc_i;
      mod_q    <= '0;
      pend_q   <= '0;
      prolog_q <= cfg_alloc_i ? prolog_n : '0;
      if (cfg_alloc_i) begin
        cur_q    <= cfg_i.addr;
        stride_q <= cfg_i.stride;
        trig_q   <= cfg_i.trig;
        every_q  <= cfg_i.every;
        blk_q    <= cfg_i.blk;
      end
    end else begin
      mod_q    <= mod_d;
      pend_q   <= pend_d;
      prolog_q <= prolog_d;
      if (grant_i) cur_q <= cur_q + stride_q;
    end
  end

  assign valid_o = valid_q;
  assign want_o  = valid_q && (pend_q != '0 || prolog_q != '0);
  assign addr_o  = cur_q;
  assign blk_o   = blk_q;

  // R3
  adv_on_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && !cfg_we_i) |=> cur_q == $past(cur_q + stride_q));
  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_i && !cfg_we_i) |=> $stable(cur_q));
  // R6
  pend_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == PEND_MAX && hit && !dec_pend && !cfg_we_i) |=> pend_q == PEND_MAX);
  // R4
  free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_alloc_i) |=> !want_o && !valid_o);
endmodule

// File: rtl/spt_arbiter.sv
module spt_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  want_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (want_i[i] && !any_o) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        any_o    = 1'b1;
      end
    end
  end

  // R5
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (any_o == |want_i));
  // R5
  lowest_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> ((want_i & (gnt_o - N'(1))) == '0));
endmodule

// File: rtl/stream_prefetch_table.sv
module stream_prefetch_table
  import spt_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int MEM_LAT     = 20,
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_valid_i,
  input  logic              cfg_alloc_i,
  input  logic [IW-1:0]     cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [ADDR_W-1:0] cfg_stride_i,
  input  logic [ADDR_W-1:0] cfg_trig_i,
  input  logic [CNT_W-1:0]  cfg_every_i,
  input  logic [CNT_W-1:0]  cfg_body_i,
  input  logic [BLK_W-1:0]  cfg_blk_i,
  input  logic              ret_valid_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [BLK_W-1:0]  req_blk_o,
  output logic [IW-1:0]     req_id_o
);
  spt_cfg_t cfg;
  logic [NUM_ENTRIES-1:0] valid, want, gnt;
  logic [ADDR_W-1:0]      addr [NUM_ENTRIES];
  logic [BLK_W-1:0]       blk  [NUM_ENTRIES];

  assign cfg = '{addr: cfg_addr_i, stride: cfg_stride_i, trig: cfg_trig_i,
                 every: cfg_every_i, body: cfg_body_i, blk: cfg_blk_i};

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    spt_entry #(.MEM_LAT(MEM_LAT)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_we_i    (cfg_valid_i && (cfg_idx_i == IW'(g))),
      .cfg_alloc_i (cfg_alloc_i),
      .cfg_i       (cfg),
      .ret_valid_i (ret_valid_i),
      .ret_pc_i    (ret_pc_i),
      .grant_i     (gnt[g] && req_ready_i),
      .valid_o     (valid[g]),
      .want_o      (want[g]),
      .addr_o      (addr[g]),
      .blk_o       (blk[g])
    );
  end

  spt_arbiter #(.N(NUM_ENTRIES)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .want_i (want),
    .gnt_o  (gnt),
    .idx_o  (req_id_o),
    .any_o  (req_valid_o)
  );

  assign req_addr_o = addr[req_id_o];
  assign req_blk_o  = blk[req_id_o];

  // R1
  req_from_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> valid[req_id_o]);
endmodule

// File: tb/tb_stream_prefetch_table.sv
`timescale 1ns/1ps
module tb_stream_prefetch_table;
  localparam int N = 4;
  localparam int LAT = 20;

  logic clk = 0, rst_n = 0;
  logic cfg_v = 0, cfg_alloc = 0;
  logic [1:0] cfg_idx = 0;
  logic [31:0] cfg_addr = 0, cfg_stride = 0, cfg_trig = 0;
  logic [7:0] cfg_every = 0, cfg_body = 0;
  logic [3:0] cfg_blk = 0;
  logic ret_v = 0, ready = 0;
  logic [31:0] ret_pc = 0;
  logic req_v;
  logic [31:0] req_addr;
  logic [3:0] req_blk;
  logic [1:0] req_id;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  stream_prefetch_table #(.NUM_ENTRIES(N), .MEM_LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_valid_i(cfg_v), .cfg_alloc_i(cfg_alloc), .cfg_idx_i(cfg_idx),
    .cfg_addr_i(cfg_addr), .cfg_stride_i(cfg_stride), .cfg_trig_i(cfg_trig),
    .cfg_every_i(cfg_every), .cfg_body_i(cfg_body), .cfg_blk_i(cfg_blk),
    .ret_valid_i(ret_v), .ret_pc_i(ret_pc),
    .req_valid_o(req_v), .req_ready_i(ready),
    .req_addr_o(req_addr), .req_blk_o(req_blk), .req_id_o(req_id)
  );

  // reference model
  logic        m_valid [N];
  logic [31:0] m_cur [N], m_stride [N], m_trig [N];
  int          m_every [N], m_cnt [N], m_pend [N], m_prolog [N];
  logic [3:0]  m_blk [N];

  function automatic int exp_pick();
    for (int i = 0; i < N; i++)
      if (m_valid[i] && (m_pend[i] > 0 || m_prolog[i] > 0)) return i;
    return -1;
  endfunction

  function automatic int prolog_of(int body);
    if (body == 0) return 0;
    return (LAT + body - 1) / body;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_cur[i] = 0; m_stride[i] = 0; m_trig[i] = 0;
      m_every[i] = 0; m_cnt[i] = 0; m_pend[i] = 0; m_prolog[i] = 0; m_blk[i] = 0;
    end
  endtask

  task automatic model_update();
    int g;
    g = ready ? exp_pick() : -1;
    for (int i = 0; i < N; i++) begin
      bit hit, dec;
      hit = 0;
      if (m_valid[i] && ret_v && ret_pc == m_trig[i]) begin
        if (m_every[i] <= 1) hit = 1;
        else if (m_cnt[i] == m_every[i] - 1) begin hit = 1; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end
      dec = 0;
      if (g == i) begin
        if (m_prolog[i] > 0) m_prolog[i]--;
        else dec = 1;
        m_cur[i] = m_cur[i] + m_stride[i];
      end
      if (hit && !dec && m_pend[i] < 3) m_pend[i]++;
      else if (dec && !hit) m_pend[i]--;
    end
    if (cfg_v) begin
      int k;
      k = int'(cfg_idx);
      m_valid[k] = cfg_alloc; m_cnt[k] = 0; m_pend[k] = 0;
      m_prolog[k] = cfg_alloc ? prolog_of(int'(cfg_body)) : 0;
      if (cfg_alloc) begin
        m_cur[k] = cfg_addr; m_stride[k] = cfg_stride; m_trig[k] = cfg_trig;
        m_every[k] = int'(cfg_every); m_blk[k] = cfg_blk;
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int p;
    p = exp_pick();
    chk({tag, " valid"}, 32'(req_v), (p >= 0) ? 32'd1 : 32'd0);
    if (p >= 0 && req_v === 1'b1) begin
      chk({tag, " addr"}, req_addr, m_cur[p]);
      chk({tag, " R9 blk"}, 32'(req_blk), 32'(m_blk[p]));
      chk({tag, " R5 id"}, 32'(req_id), 32'(p));
    end
  endtask

  // called just after a negedge with inputs set
  task automatic step(string tag);
    #1 compare(tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    cfg_v = 0; ret_v = 0;
  endtask

  task automatic alloc(int idx, logic [31:0] a, logic [31:0] s, logic [31:0] t,
                       int every, int body, int blk, string tag);
    cfg_v = 1; cfg_alloc = 1; cfg_idx = 2'(idx); cfg_addr = a; cfg_stride = s;
    cfg_trig = t; cfg_every = 8'(every); cfg_body = 8'(body); cfg_blk = 4'(blk);
    step(tag);
  endtask

  task automatic free_slot(int idx, string tag);
    cfg_v = 1; cfg_alloc = 0; cfg_idx = 2'(idx);
    step(tag);
  endtask

  task automatic fire(logic [31:0] pc, string tag);
    ret_v = 1; ret_pc = pc;
    step(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1 chk("R1 in reset", 32'(req_v), 32'd0);
    rst_n = 1;
    @(negedge clk);
    idle(2, "R1");

    // R2 / R3 basic stream
    ready = 1;
    alloc(1, 32'h1000, 32'd64, 32'h400, 0, 0, 6, "R2");
    fire(32'h400, "R3");
    #1 chk("R3 first addr", req_addr, 32'h1000);
    idle(1, "R3");
    fire(32'h404, "R3 nomatch");
    fire(32'h400, "R3");
    #1 chk("R3 second addr", req_addr, 32'h1040);
    idle(2, "R3");

    // R3 wrap and negative stride
    alloc(0, 32'hFFFF_FFF0, 32'h20, 32'h480, 1, 0, 2, "R3 wrap");
    fire(32'h480, "R3 wrap");
    fire(32'h480, "R3 wrap");
    #1 chk("R3 wrapped addr", req_addr, 32'h0000_0010);
    idle(1, "R3 wrap");
    alloc(0, 32'h10, 32'hFFFF_FFE0, 32'h480, 0, 0, 3, "R3 neg");
    fire(32'h480, "R3 neg"); fire(32'h480, "R3 neg");
    #1 chk("R3 neg addr", req_addr, 32'hFFFF_FFF0);
    idle(2, "R3 neg");

    // R5 simultaneous matches
    alloc(0, 32'hA000, 32'd4, 32'h500, 0, 0, 1, "R5");
    alloc(2, 32'hB000, 32'd4, 32'h500, 0, 0, 2, "R5");
    alloc(3, 32'hC000, 32'd4, 32'h500, 0, 0, 3, "R5");
    fire(32'h500, "R5");
    #1 chk("R5 first id", 32'(req_id), 32'd0);
    idle(1, "R5");
    #1 chk("R5 second id", 32'(req_id), 32'd2);
    idle(3, "R5");

    // R6 stall saturation
    free_slot(0, "R4"); free_slot(2, "R4"); free_slot(3, "R4");
    ready = 0;
    for (int i = 0; i < 5; i++) fire(32'h400, "R6 stall");
    #1 chk("R6 addr held", req_addr, m_cur[1]);
    ready = 1;
    idle(3, "R6 drain");
    #1 chk("R6 drained", 32'(req_v), 32'd0);
    idle(1, "R6");

    // R7 divider
    alloc(2, 32'h2000, 32'd8, 32'h600, 3, 0, 5, "R7");
    for (int i = 0; i < 6; i++) begin
      fire(32'h600, "R7");
      idle(1, "R7");
    end

    // R8 prolog: ceil(20/6) = 4, with stall then release
    ready = 0;
    alloc(3, 32'h3000, 32'd16, 32'h700, 0, 6, 7, "R8");
    fire(32'h700, "R8");
    ready = 1;
    idle(6, "R8");
    #1 chk("R8 final addr next", 32'(req_v), 32'd0);
    alloc(3, 32'h3000, 32'd16, 32'h700, 0, 1, 7, "R8 body1");
    idle(22, "R8 body1");
    alloc(3, 32'h3000, 32'd16, 32'h700, 0, 0, 7, "R8 body0");
    #1 chk("R8 no prolog", 32'(req_v), 32'd0);
    idle(1, "R8");

    // R4 free / invalid
    free_slot(1, "R4");
    fire(32'h400, "R4 freed");
    #1 chk("R4 freed no req", 32'(req_v), 32'd0);
    fire(32'h999, "R4 unknown");
    // R2 overwrite live slot
    alloc(3, 32'h5000, 32'd4, 32'h704, 0, 0, 9, "R2 ovr");
    fire(32'h700, "R2 old trig");
    fire(32'h704, "R2 new trig");
    #1 chk("R2 overwrite addr", req_addr, 32'h5000);
    idle(2, "R2");

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      ready = ($urandom % 10) < 7;
      if ($urandom % 20 == 0) begin
        cfg_v = 1; cfg_alloc = ($urandom % 4) != 0; cfg_idx = 2'($urandom % 4);
        cfg_addr = ($urandom % 2) ? $urandom : 32'hFFFF_FF00 + ($urandom % 256);
        cfg_stride = ($urandom % 2) ? 32'($urandom % 128) : -32'($urandom % 128);
        cfg_trig = 32'h100 + 32'(($urandom % 4) * 4);
        cfg_every = 8'($urandom % 4);
        cfg_body = ($urandom % 5 == 0) ? 8'($urandom % 8) : 8'd0;
        cfg_blk = 4'($urandom);
      end
      if ($urandom % 3 != 0) begin
        ret_v = 1; ret_pc = 32'h100 + 32'(($urandom % 5) * 4);
      end
      step("R3 random");
    end
    summary();
  end
endmodule